// File: doc/BRIEF.md
# Character Display Row Scan Generator

This block drives the multiplexed rows of a dot-matrix character panel. An oscillator enable advances a tick counter, and each common (row) line stays selected for a fixed window of ticks. The scan cycles through 8, 11 or 16 commons, chosen by the line-count and tall-font mode bits. While one common is shown, the block fetches the dots of the next row one at a time. It asks an external glyph lookup for each cell's pattern row through a fetch address, and it receives five dots back in the same cycle.

The first 40 dots move serially into an internal shift register. At the end of the window they are copied in parallel into the segment latch, and the commons advance on that same edge. The remaining 40 dots go out on a serial line with its own shift clock, and a latch strobe tells an external column expander to load them. A frame alternation output flips once per frame so that the analogue stage can drive the panel with AC.

The block also applies display-off blanking, a cursor underline and a blinking cursor cell while it forms the dots.

Top module: `lcd_scan_gen`

## Requirements
- R1: While reset is held low at a clock edge, the block drives com = 16'h0001, seg = 0, m_alt = 0, ext_sclk = 0 and ext_lat = 0.
- R2: A common advances only on clock edges where osc_tick is high. Each common stays active for exactly ROW_TICKS (400) ticks, so with osc_tick high every other cycle a window lasts 800 cycles.
- R3: Exactly one bit of com is high, and the active index steps 0,1,2,... and wraps to 0. The wrap follows row 7 when two_line=0 and tall_font=0, row 10 when two_line=0 and tall_font=1, and row 15 when two_line=1, in which case tall_font is ignored. If the mode shrinks while the active row is past the new end, the next row is 0.
- R4: While common k is active, seg[5c+j] (c = 0..7, j = 0..4) holds font_row bit 4-j as returned for fetch_cell = c, fetch_line = (two_line && k>=8), and fetch_row = (two_line ? k mod 8 : k). The segment latch loads on the same edge the commons change and holds between those edges.
- R5: Dots of cells 8..15 for the next row leave on ext_data, one per rising edge of ext_sclk, 40 edges per window. The first dot is cell 8's leftmost dot, and ext_data is stable at each rising edge. ext_lat is high for one cycle, starting on the edge where the commons advance.
- R6: m_alt toggles on the edge where common 0 becomes active, and at no other time.
- R7: With disp_on=0, every segment and extension dot is 0, including the cursor cell.
- R8: With cursor_on=1, the cell at (cur_line, cur_cell) shows all five dots on in its last pattern row. That row is 10 in 1-line tall-font mode and 7 otherwise. Its other rows show the pattern.
- R9: A blink phase starts at 0 after reset and toggles each BLINK_FRAMES-th time common 0 becomes active. With blink_on=1 and phase 1, every row of the cursor cell shows all dots on. Rows fetched before the toggling edge use the old phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick enable |
| two_line | input | 1 | 1 = two text lines, 16 commons |
| tall_font | input | 1 | 1 = tall glyphs (11 rows) in one-line mode |
| disp_on | input | 1 | 0 blanks all dots |
| cursor_on | input | 1 | Underline cursor enable |
| blink_on | input | 1 | Blinking cursor cell enable |
| cur_line | input | 1 | Cursor text line |
| cur_cell | input | 4 | Cursor cell index 0..15 |
| font_row | input | 5 | Pattern row for the fetched cell, bit 4 leftmost |
| fetch_line | output | 1 | Text line being fetched |
| fetch_cell | output | 4 | Cell being fetched |
| fetch_row | output | 4 | Glyph row being fetched |
| com | output | 16 | One-hot common select |
| seg | output | 40 | Latched segment dots |
| ext_sclk | output | 1 | Extension shift clock |
| ext_lat | output | 1 | Extension latch strobe |
| ext_data | output | 1 | Extension serial dots |
| m_alt | output | 1 | Frame alternation for AC drive |

## Verification
The commons, the segment latch and m_alt all change on the edge that ends a window, which is the ROW_TICKS-th tick edge after the previous change. The latch strobe is high for that single cycle. The bench samples at the falling edge and treats any change of com as the point where the row index, seg, m_alt, ext_lat and the received extension dots are all due together. It checks the cycle distance to the previous change against the tick rate in use. Extension dots are gathered at each rising ext_sclk, and the window's 40 dots are compared when the commons next advance.

// File: rtl/lcd_scan_pkg.sv
// Shared types for the row scan generator.
// Assumes: the mode bits are quasi-static and change only between windows.
package lcd_scan_pkg;

    // Mode bits sampled by the dot forming logic.
    typedef struct packed {
        logic two_line;
        logic tall_font;
        logic disp_on;
        logic cursor_on;
        logic blink_on;
    } scan_mode_t;

endpackage

// File: rtl/lcd_row_timer.sv
// Tick counter, common row sequencer, frame alternation and blink phase.
// Assumes: ROW_TICKS >= 2 and NUM_COM >= ROWS_TALL >= ROWS_SHORT.
module lcd_row_timer #(
    parameter int ROW_TICKS    = 400,
    parameter int NUM_COM      = 16,
    parameter int ROWS_SHORT   = 8,
    parameter int ROWS_TALL    = 11,
    parameter int BLINK_FRAMES = 32,
    localparam int TCNT_W = $clog2(ROW_TICKS),
    localparam int ROW_AW = $clog2(NUM_COM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              two_line,
    input  logic              tall_font,
    output logic [TCNT_W-1:0] tcnt,
    output logic              row_end,
    output logic [ROW_AW-1:0] cur_row,
    output logic [ROW_AW-1:0] nxt_row,
    output logic              m_alt,
    output logic              blink_ph
);
    localparam int FCNT_W = $clog2(BLINK_FRAMES + 1);
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(ROW_TICKS - 1);
    localparam logic [FCNT_W-1:0] FCNT_LAST = FCNT_W'(BLINK_FRAMES - 1);

    logic [ROW_AW:0]   duty;
    logic [ROW_AW:0]   row_inc;
    logic [FCNT_W-1:0] fcnt;

    // Number of commons scanned in the current mode.
    always_comb begin
        if (two_line)       duty = (ROW_AW+1)'(NUM_COM);
        else if (tall_font) duty = (ROW_AW+1)'(ROWS_TALL);
        else                duty = (ROW_AW+1)'(ROWS_SHORT);
    end

    // Next common index with wrap, also covering a mode that just shrank.
    always_comb begin
        row_inc = {1'b0, cur_row} + 1'b1;
        nxt_row = (row_inc >= duty) ? '0 : row_inc[ROW_AW-1:0];
        row_end = tick && (tcnt == TCNT_LAST);
    end

    // Tick counter within one common window.
    always_ff @(posedge clk) begin
        if (!rst_n)    tcnt <= '0;
        else if (tick) tcnt <= (tcnt == TCNT_LAST) ? '0 : tcnt + 1'b1;
    end

    // Common advance, frame alternation and blink phase at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row  <= '0;
            m_alt    <= 1'b0;
            fcnt     <= '0;
            blink_ph <= 1'b0;
        end else if (row_end) begin
            cur_row <= nxt_row;
            if (nxt_row == '0) begin
                m_alt <= ~m_alt;
                if (fcnt == FCNT_LAST) begin
                    fcnt     <= '0;
                    blink_ph <= ~blink_ph;
                end else begin
                    fcnt <= fcnt + 1'b1;
                end
            end
        end
    end

    AST_ROW_IN_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, nxt_row} < duty);                                          // R3
    AST_M_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (m_alt != $past(m_alt)) |-> (cur_row == '0));                     // R6
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(row_end) |-> $stable(cur_row));                            // R2
endmodule

// File: rtl/lcd_dot_fetch.sv
// Fetch addressing and dot forming for the row after the one displayed.
// Dot d is handled on tick 2d of the window; the odd tick after an
// extension dot raises the shift clock.
// Assumes: 2*(NUM_SEG+EXT_SEG) <= ROW_TICKS and font_row is combinational.
module lcd_dot_fetch
    import lcd_scan_pkg::*;
#(
    parameter int ROW_TICKS  = 400,
    parameter int NUM_COM    = 16,
    parameter int NUM_SEG    = 40,
    parameter int EXT_SEG    = 40,
    parameter int CELL_W     = 5,
    parameter int ROWS_SHORT = 8,
    parameter int ROWS_TALL  = 11,
    localparam int TCNT_W    = $clog2(ROW_TICKS),
    localparam int ROW_AW    = $clog2(NUM_COM),
    localparam int NUM_CELLS = (NUM_SEG + EXT_SEG) / CELL_W,
    localparam int CELL_AW   = $clog2(NUM_CELLS)
) (
    input  logic               tick,
    input  logic [TCNT_W-1:0]  tcnt,
    input  logic [ROW_AW-1:0]  nxt_row,
    input  scan_mode_t         mode,
    input  logic               blink_ph,
    input  logic               cur_line,
    input  logic [CELL_AW-1:0] cur_cell,
    input  logic [CELL_W-1:0]  font_row,
    output logic               fetch_line,
    output logic [CELL_AW-1:0] fetch_cell,
    output logic [ROW_AW-1:0]  fetch_row,
    output logic               pix,
    output logic               shift_int,
    output logic               shift_ext,
    output logic               sclk_rise
);
    localparam int COL_W = $clog2(CELL_W);
    localparam int HALF  = NUM_COM / 2;
    localparam logic [COL_W-1:0]  COL_LAST = COL_W'(CELL_W - 1);
    localparam logic [TCNT_W-1:0] SEG_END  = TCNT_W'(NUM_SEG);
    localparam logic [TCNT_W-1:0] DOT_END  = TCNT_W'(NUM_SEG + EXT_SEG);

    logic [TCNT_W-1:0] dot;
    logic [COL_W-1:0]  col;
    logic [ROW_AW-1:0] last_row;
    logic              at_cursor;
    logic              in_ext;

    // Dot, cell and column indices from the tick count.
    always_comb begin
        dot        = tcnt >> 1;
        fetch_cell = CELL_AW'(dot / TCNT_W'(CELL_W));
        col        = COL_W'(dot % TCNT_W'(CELL_W));
    end

    // Text line and glyph row addressed by the next common.
    always_comb begin
        fetch_line = mode.two_line && (nxt_row >= ROW_AW'(HALF));
        fetch_row  = mode.two_line ? ROW_AW'(nxt_row % ROW_AW'(HALF)) : nxt_row;
        last_row   = (!mode.two_line && mode.tall_font) ? ROW_AW'(ROWS_TALL - 1)
                                                        : ROW_AW'(ROWS_SHORT - 1);
    end

    // Dot value with blanking, blink and underline applied.
    always_comb begin
        at_cursor = (fetch_line == cur_line) && (fetch_cell == cur_cell);
        pix = mode.disp_on &&
              ((at_cursor && mode.blink_on && blink_ph) ||
               (at_cursor && mode.cursor_on && (fetch_row == last_row)) ||
               font_row[COL_LAST - col]);
    end

    // Shift strobes for the internal register and the extension line.
    always_comb begin
        in_ext    = (dot >= SEG_END) && (dot < DOT_END);
        shift_int = tick && !tcnt[0] && (dot < SEG_END);
        shift_ext = tick && !tcnt[0] && in_ext;
        sclk_rise = tick &&  tcnt[0] && in_ext;
    end
endmodule

// File: rtl/lcd_seg_shift.sv
// Serial segment shift register, parallel segment latch and the
// extension driver outputs.
// Assumes: shift strobes come from lcd_dot_fetch, row_end from the timer.
module lcd_seg_shift #(
    parameter int NUM_SEG = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix,
    input  logic               shift_int,
    input  logic               shift_ext,
    input  logic               sclk_rise,
    input  logic               row_end,
    output logic [NUM_SEG-1:0] seg,
    output logic               ext_data,
    output logic               ext_sclk,
    output logic               ext_lat
);
    logic [NUM_SEG-1:0] sreg;

    // Internal shift: the first dot of a row ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         sreg <= '0;
        else if (shift_int) sreg <= {pix, sreg[NUM_SEG-1:1]};
    end

    // Parallel transfer into the segment latch at window end.
    always_ff @(posedge clk) begin
        if (!rst_n)       seg <= '0;
        else if (row_end) seg <= sreg;
    end

    // Extension data and shift clock, the clock rising one tick after data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_data <= 1'b0;
            ext_sclk <= 1'b0;
        end else if (shift_ext) begin
            ext_data <= pix;
            ext_sclk <= 1'b0;
        end else if (sclk_rise) begin
            ext_sclk <= 1'b1;
        end
    end

    // One-cycle extension latch strobe aligned with the common change.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_lat <= 1'b0;
        else        ext_lat <= row_end;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(row_end) |-> $stable(seg));                                // R4
    AST_SCLK_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_sclk) |-> $stable(ext_data));                           // R5
endmodule

// File: rtl/lcd_scan_gen.sv
// Top of the row scan generator: timer, dot fetch and segment shifter,
// plus the one-hot common decode.
// Assumes: osc_tick is a single-cycle enable synchronous to clk.
module lcd_scan_gen
    import lcd_scan_pkg::*;
#(
    parameter int ROW_TICKS    = 400,
    parameter int NUM_COM      = 16,
    parameter int NUM_SEG      = 40,
    parameter int EXT_SEG      = 40,
    parameter int CELL_W       = 5,
    parameter int ROWS_SHORT   = 8,
    parameter int ROWS_TALL    = 11,
    parameter int BLINK_FRAMES = 32,
    localparam int ROW_AW    = $clog2(NUM_COM),
    localparam int NUM_CELLS = (NUM_SEG + EXT_SEG) / CELL_W,
    localparam int CELL_AW   = $clog2(NUM_CELLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_tick,
    input  logic               two_line,
    input  logic               tall_font,
    input  logic               disp_on,
    input  logic               cursor_on,
    input  logic               blink_on,
    input  logic               cur_line,
    input  logic [CELL_AW-1:0] cur_cell,
    input  logic [CELL_W-1:0]  font_row,
    output logic               fetch_line,
    output logic [CELL_AW-1:0] fetch_cell,
    output logic [ROW_AW-1:0]  fetch_row,
    output logic [NUM_COM-1:0] com,
    output logic [NUM_SEG-1:0] seg,
    output logic               ext_sclk,
    output logic               ext_lat,
    output logic               ext_data,
    output logic               m_alt
);
    localparam int TCNT_W = $clog2(ROW_TICKS);

    scan_mode_t        mode;
    logic [TCNT_W-1:0] tcnt;
    logic              row_end;
    logic [ROW_AW-1:0] cur_row;
    logic [ROW_AW-1:0] nxt_row;
    logic              blink_ph;
    logic              pix;
    logic              shift_int;
    logic              shift_ext;
    logic              sclk_rise;

    // Gather the mode bits into one bundle.
    always_comb begin
        mode = '{two_line: two_line, tall_font: tall_font, disp_on: disp_on,
                 cursor_on: cursor_on, blink_on: blink_on};
    end

    lcd_row_timer #(
        .ROW_TICKS(ROW_TICKS), .NUM_COM(NUM_COM), .ROWS_SHORT(ROWS_SHORT),
        .ROWS_TALL(ROWS_TALL), .BLINK_FRAMES(BLINK_FRAMES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick),
        .two_line(two_line), .tall_font(tall_font),
        .tcnt(tcnt), .row_end(row_end), .cur_row(cur_row), .nxt_row(nxt_row),
        .m_alt(m_alt), .blink_ph(blink_ph)
    );

    lcd_dot_fetch #(
        .ROW_TICKS(ROW_TICKS), .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG),
        .EXT_SEG(EXT_SEG), .CELL_W(CELL_W), .ROWS_SHORT(ROWS_SHORT),
        .ROWS_TALL(ROWS_TALL)
    ) u_fetch (
        .tick(osc_tick), .tcnt(tcnt), .nxt_row(nxt_row), .mode(mode),
        .blink_ph(blink_ph), .cur_line(cur_line), .cur_cell(cur_cell),
        .font_row(font_row), .fetch_line(fetch_line), .fetch_cell(fetch_cell),
        .fetch_row(fetch_row), .pix(pix), .shift_int(shift_int),
        .shift_ext(shift_ext), .sclk_rise(sclk_rise)
    );

    lcd_seg_shift #(
        .NUM_SEG(NUM_SEG)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .pix(pix), .shift_int(shift_int),
        .shift_ext(shift_ext), .sclk_rise(sclk_rise), .row_end(row_end),
        .seg(seg), .ext_data(ext_data), .ext_sclk(ext_sclk), .ext_lat(ext_lat)
    );

    // One-hot common select from the displayed row index.
    always_comb begin
        com = '0;
        com[cur_row] = 1'b1;
    end

    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com) == 1);                                            // R3
    AST_BLANK_DOTS: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> !pix);                                               // R7
    AST_LAT_WITH_COM: assert property (@(posedge clk) disable iff (!rst_n)
        ext_lat |-> (com != $past(com)));                                 // R5
endmodule

// File: tb/test_lcd_scan_gen.sv
module test_lcd_scan_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BLINK_N    = 2;
    localparam int WD_LIMIT   = 190000;

    typedef struct packed {
        logic       two;
        logic       tall;
        logic       disp;
        logic       cur;
        logic       blink;
        logic       cline;
        logic [3:0] ccell;
        logic [4:0] duty;
        logic [3:0] frames;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  5'd8,  4'd2},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9,  5'd11, 4'd2},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2,  5'd16, 4'd2},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5,  5'd16, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  5'd8,  4'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_lvl = 1'b1;
    logic tick_half = 1'b0;
    logic half_rate = 1'b0;
    logic osc_tick;
    logic two_line = 1'b0, tall_font = 1'b0, disp_on = 1'b1;
    logic cursor_on = 1'b0, blink_on = 1'b0, cur_line = 1'b0;
    logic [3:0] cur_cell = 4'd0;
    logic [4:0] font_row;
    logic fetch_line;
    logic [3:0] fetch_cell, fetch_row;
    logic [15:0] com;
    logic [39:0] seg;
    logic ext_sclk, ext_lat, ext_data, m_alt;

    int checks = 0, fails = 0, wd = 0;

    // Monitor state
    logic mon_en = 1'b0;
    logic have_prev;
    int prev_r, cyc, acts, rows_seen, sclk_base, sclk_cnt = 0;
    int exp_win = 400;
    int duty_e = 8;
    logic prev_m, phase;
    logic [39:0] ebuf = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign osc_tick = half_rate ? tick_half : tick_lvl;

    lcd_scan_gen #(.BLINK_FRAMES(BLINK_N)) i_lcd_scan_gen (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .two_line(two_line),
        .tall_font(tall_font), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .cur_line(cur_line), .cur_cell(cur_cell),
        .font_row(font_row), .fetch_line(fetch_line), .fetch_cell(fetch_cell),
        .fetch_row(fetch_row), .com(com), .seg(seg), .ext_sclk(ext_sclk),
        .ext_lat(ext_lat), .ext_data(ext_data), .m_alt(m_alt)
    );

    // Glyph lookup model
    function automatic logic [4:0] fnt(logic ln, logic [3:0] c, logic [3:0] r);
        int v;
        v = (int'(c) * 7 + int'(r) * 3 + (ln ? 11 : 0) + 5) ^ (int'(r) << 2);
        return 5'(v);
    endfunction
    assign font_row = fnt(fetch_line, fetch_cell, fetch_row);

    // Expected 40 dots of row r, cells base..base+7
    function automatic logic [39:0] exp_dots(int r, int base, logic ph);
        logic [39:0] d;
        logic ln;
        int crow, lastr;
        logic [4:0] p;
        d = '0;
        ln = two_line && (r >= 8);
        crow = two_line ? r % 8 : r;
        lastr = (!two_line && tall_font) ? 10 : 7;
        for (int c = 0; c < 8; c++) begin
            p = fnt(ln, 4'(base + c), 4'(crow));
            if (ln == cur_line && (base + c) == int'(cur_cell)) begin
                if (blink_on && ph) p = 5'h1f;
                else if (cursor_on && crow == lastr) p = 5'h1f;
            end
            if (!disp_on) p = 5'h0;
            for (int j = 0; j < 5; j++) d[5*c + j] = p[4-j];
        end
        return d;
    endfunction

    function automatic string seg_tag();
        if (!disp_on) return "R7";
        if (blink_on) return "R9";
        if (cursor_on) return "R8";
        return "R4";
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) if (half_rate) tick_half <= ~tick_half;
    always @(posedge ext_sclk) begin
        ebuf <= {ext_data, ebuf[39:1]};
        sclk_cnt <= sclk_cnt + 1;
    end

    // Row monitor: every change of com is the point where all results are due
    always @(negedge clk) begin
        if (mon_en) begin
            int r, er;
            cyc++;
            if (com != (16'h1 << prev_r)) begin
                r = -1;
                for (int i = 0; i < 16; i++) if (com[i]) r = i;
                er = (prev_r + 1 >= duty_e) ? 0 : prev_r + 1;
                chk($countones(com) == 1 && r == er, "R3", "row index",
                    64'(com), 64'(16'h1 << er));
                if (have_prev)
                    chk(cyc == exp_win, "R2", "window cycles", 64'(cyc), 64'(exp_win));
                chk(seg == exp_dots(r, 0, phase), seg_tag(), "segments",
                    64'(seg), 64'(exp_dots(r, 0, phase)));
                chk(ebuf == exp_dots(r, 8, phase) && (sclk_cnt - sclk_base) == 40
                    && ext_lat, "R5", "extension dots",
                    {24'(sclk_cnt - sclk_base), ebuf}, {24'd40, exp_dots(r, 8, phase)});
                chk(m_alt == ((r == 0) ? !prev_m : prev_m), "R6", "alternation",
                    64'(m_alt), 64'((r == 0) ? !prev_m : prev_m));
                if (r == 0) begin
                    acts++;
                    if (acts % BLINK_N == 0) phase = !phase;
                end
                prev_m = m_alt;
                prev_r = r;
                cyc = 0;
                sclk_base = sclk_cnt;
                have_prev = 1'b1;
                rows_seen++;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual %0d expected below %0d", wd, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic do_reset(input logic check_r1);
        mon_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        if (check_r1) begin
            chk(com == 16'h0001, "R1", "reset com", 64'(com), 64'h1);
            chk(seg == '0, "R1", "reset seg", 64'(seg), 64'h0);
            chk({m_alt, ext_sclk, ext_lat} == 3'b000, "R1", "reset m/sclk/lat",
                64'({m_alt, ext_sclk, ext_lat}), 64'h0);
        end
        rst_n = 1'b1;
        prev_r = 0; cyc = 0; acts = 0; rows_seen = 0;
        prev_m = 1'b0; phase = 1'b0; have_prev = 1'b0;
        sclk_base = sclk_cnt;
        mon_en = 1'b1;
    endtask

    task automatic wait_rows(input int n);
        while (rows_seen < n) @(negedge clk);
    endtask

    initial begin
        // Table-driven modes: duty, content, cursor, blink, blanking
        for (int v = 0; v < 5; v++) begin
            two_line = VECS[v].two; tall_font = VECS[v].tall;
            disp_on = VECS[v].disp; cursor_on = VECS[v].cur;
            blink_on = VECS[v].blink; cur_line = VECS[v].cline;
            cur_cell = VECS[v].ccell;
            duty_e = int'(VECS[v].duty);
            do_reset(v == 0);
            wait_rows(int'(VECS[v].duty) * int'(VECS[v].frames));
        end

        // R1 reset again mid-scan, then R2 tick hold
        two_line = 1'b0; tall_font = 1'b0; disp_on = 1'b1;
        cursor_on = 1'b0; blink_on = 1'b0; duty_e = 8;
        tick_lvl = 1'b0;
        do_reset(1'b1);
        repeat (1000) @(negedge clk);
        chk(com == 16'h0001 && seg == '0, "R2", "hold without ticks",
            {seg, com[7:0]}, 64'h01);

        // R2 half-rate ticks stretch the window to 800 cycles
        exp_win = 800;
        half_rate = 1'b1;
        wait_rows(3);
        half_rate = 1'b0;
        tick_lvl = 1'b1;
        exp_win = 400;

        // R3 mode shrinks while row 12 is active: next row is 0
        two_line = 1'b1; duty_e = 16;
        do_reset(1'b0);
        @(negedge clk iff com[12]);
        #1;
        two_line = 1'b0; tall_font = 1'b0; duty_e = 8;
        wait_rows(16);
        chk(rows_seen >= 16, "R3", "rows after shrink", 64'(rows_seen), 64'd16);

        mon_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule